// File: doc/BRIEF.md
# KCS Mailbox Controller

This block is a four-channel keyboard-controller-style mailbox that sits between a host-facing side and a management-controller side. Each channel carries one input data word (host to controller), one output data word (controller to host) and a status word whose low bits serve as the handshake flags. The host side writes a channel's input data or reads its output data through a simple per-channel strobe port. The controller side sees every register through a 32-bit register port that is addressed by word and covers a 4 KB window.

The flags change as side effects of access. A host data write marks the input buffer full. A controller read of that input data marks it empty. A controller write of output data marks the output buffer full, and a host read of the output data empties it. Each channel can raise its own input-buffer interrupt, but only while the channel is enabled and its interrupt enable is set. A separate pending vector follows a set of level inputs, and the OR of that vector drives one combined interrupt line.

Top module: `kcs_mbox`

## Requirements
- R1: On reset every register word reads zero, except word 0x22 (byte offset 0x88), which holds the `CFG_RESET` parameter. `kcsIrq` and `irqAny` are low after reset.
- R2: A controller read (`bmcValid`=1, `bmcWrite`=0) shows the addressed word on `bmcRdata` after the next rising edge, with the value held before that edge. Word addresses at or above `REG_WORDS` (default 72) read as zero, and writes to them change nothing.
- R3: A host data write (`hostWrEn[c]`=1, `hostWrSel[c]`=0) stores the byte, zero-extended, in the channel's input word and sets the input-full flag (status bit 1). The input words sit at word 0x09, 0x0A, 0x0B and 0x45, and the status words at 0x0F, 0x10, 0x11 and 0x47, for channels 0 to 3.
- R4: A controller read of an input word clears that channel's input-full flag. If a host data write to the same channel falls in the same cycle, the flag stays set.
- R5: A controller write to an output word (0x0C, 0x0D, 0x0E, 0x46) stores it and sets the output-full flag (status bit 0). `hostRdData` always shows the output word's low byte. A host read (`hostRdEn[c]`) clears the output-full flag, but a controller output write in the same cycle keeps it set.
- R6: A host status write (`hostWrSel[c]`=1) changes no register. The controller port writes any status word directly. Bit 3 of the status word is the command/data flag.
- R7: The channel enables are word 0x00 bit 5 for channel 0, bit 6 for channel 1, and bit 7 for channel 2. Channel 2 also needs word 0x04 bit 2. Channel 3 is enabled by word 0x40 bit 0.
- R8: The input-interrupt enables are word 0x02 bits 1, 2 and 3 for channels 0 to 2, and word 0x40 bit 1 for channel 3. A host data write raises `kcsIrq[c]` on the next edge only when both the enable and the channel enable are set.
- R9: A controller read of an input word drops `kcsIrq[c]` only if the input-full flag was set at that read. Otherwise the interrupt holds.
- R10: Pending bit i takes `irqSrc[i]` on each edge, and `irqAny` is the OR of the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bmcValid | input | 1 | Controller access strobe |
| bmcWrite | input | 1 | 1 = write, 0 = read |
| bmcAddr | input | 10 | Word address within the 4 KB window |
| bmcWdata | input | 32 | Controller write data |
| bmcRdata | output | 32 | Registered read data |
| hostWrEn | input | 4 | Host write strobe per channel |
| hostWrSel | input | 4 | Host write target: 0 = data, 1 = status (ignored) |
| hostWrData | input | 32 | Host write byte per channel, channel c in bits 8c+7..8c |
| hostRdEn | input | 4 | Host output-data read strobe per channel |
| hostRdData | output | 32 | Output word low byte per channel |
| hostStatus | output | 32 | Status word low byte per channel |
| irqSrc | input | 5 | Level inputs of the pending vector |
| kcsIrq | output | 4 | Per-channel input-buffer interrupt |
| irqAny | output | 1 | OR of the pending vector |

## Verification
The bench aims at the collisions between the two sides. Take a controller input read against a host data write in the same cycle: a design with the wrong priority would leave the host's byte unflagged. Take a controller output write against a host output read: a design with the wrong priority would lose an output byte. The bench also drops the input-full flag through a direct status write and then reads the input word; a design that cleared the interrupt without looking at the flag would lower it there. It checks that channel 2 stays silent with only one of its two enable bits set, and that an interrupt enable on a disabled channel raises nothing. It also checks that a host status write leaves both the status and the data untouched.

// File: rtl/kcs_mbox_pkg.sv
package kcs_mbox_pkg;
  localparam int NUM_CH  = 4;
  localparam int WORD_AW = 10;
  localparam int STS_OBF = 0;
  localparam int STS_IBF = 1;
  localparam int STS_CD  = 3;
  localparam int W_ENA   = 'h00;
  localparam int W_IEN   = 'h02;
  localparam int W_ENB   = 'h04;
  localparam int W_CFG   = 'h22;
  localparam int W_EXT   = 'h40;

  function automatic int idrWord(input int c);
    return (c < 3) ? 'h09 + c : 'h45;
  endfunction
  function automatic int odrWord(input int c);
    return (c < 3) ? 'h0C + c : 'h46;
  endfunction
  function automatic int stsWord(input int c);
    return (c < 3) ? 'h0F + c : 'h47;
  endfunction

  typedef struct packed {
    logic [NUM_CH-1:0] hostIdrWr;
    logic [NUM_CH-1:0] bmcIdrRd;
    logic [NUM_CH-1:0] bmcOdrWr;
    logic [NUM_CH-1:0] hostOdrRd;
  } flagStrobe_t;
endpackage

// File: rtl/kcs_mbox_regs.sv
module kcs_mbox_regs
  import kcs_mbox_pkg::*;
#(
  parameter int          REG_WORDS = 72,
  parameter int          DATA_W    = 8,
  parameter logic [31:0] CFG_RESET = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     bmcValid,
  input  logic                     bmcWrite,
  input  logic [WORD_AW-1:0]       bmcAddr,
  input  logic [31:0]              bmcWdata,
  output logic [31:0]              bmcRdata,
  input  logic [NUM_CH*DATA_W-1:0] hostWrData,
  input  flagStrobe_t              strb,
  output logic [NUM_CH-1:0]        enRaw,
  output logic                     enGate,
  output logic [NUM_CH-1:0]        ieRaw,
  output logic [NUM_CH-1:0]        ibfVec,
  output logic [NUM_CH*DATA_W-1:0] odrByte,
  output logic [NUM_CH*8-1:0]      stsByte
);
  localparam int IDX_W = $clog2(REG_WORDS);
  localparam logic [WORD_AW:0] LIMIT = (WORD_AW+1)'(REG_WORDS);

  logic [31:0] regs [REG_WORDS];
  logic [31:0] nxt  [REG_WORDS];
  logic        inRange;

  assign inRange = ({1'b0, bmcAddr} < LIMIT);

  always_comb begin
    for (int w = 0; w < REG_WORDS; w++) begin
      nxt[w] = regs[w];
      if (bmcValid && bmcWrite && inRange && bmcAddr == WORD_AW'(w))
        nxt[w] = bmcWdata;
      for (int c = 0; c < NUM_CH; c++) begin
        if (w == idrWord(c) && strb.hostIdrWr[c])
          nxt[w] = 32'(hostWrData[c*DATA_W +: DATA_W]);
        if (w == stsWord(c)) begin
          if (strb.bmcIdrRd[c])  nxt[w][STS_IBF] = 1'b0;
          if (strb.hostIdrWr[c]) nxt[w][STS_IBF] = 1'b1;
          if (strb.hostOdrRd[c]) nxt[w][STS_OBF] = 1'b0;
          if (strb.bmcOdrWr[c])  nxt[w][STS_OBF] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < REG_WORDS; w++)
        regs[w] <= (w == W_CFG) ? CFG_RESET : '0;
    end else begin
      for (int w = 0; w < REG_WORDS; w++)
        regs[w] <= nxt[w];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bmcRdata <= '0;
    else if (bmcValid && !bmcWrite)
      bmcRdata <= inRange ? regs[bmcAddr[IDX_W-1:0]] : '0;
  end

  assign enRaw  = {regs[W_EXT][0], regs[W_ENA][7], regs[W_ENA][6], regs[W_ENA][5]};
  assign enGate = regs[W_ENB][2];
  assign ieRaw  = {regs[W_EXT][1], regs[W_IEN][3], regs[W_IEN][2], regs[W_IEN][1]};

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : gChan
      assign ibfVec[c]                    = regs[stsWord(c)][STS_IBF];
      assign odrByte[c*DATA_W +: DATA_W]  = regs[odrWord(c)][DATA_W-1:0];
      assign stsByte[c*8 +: 8]            = regs[stsWord(c)][7:0];

      // R3: a host data write leaves the input-full flag set
      assert_ibf_set_R3: assert property (@(posedge clk) disable iff (!rstN)
        strb.hostIdrWr[c] |=> ibfVec[c]);
      // R4: a controller input read without a colliding host write empties it
      assert_ibf_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
        strb.bmcIdrRd[c] && !strb.hostIdrWr[c] |=> !ibfVec[c]);
      // R5: a controller output write leaves the output-full flag set
      assert_obf_set_R5: assert property (@(posedge clk) disable iff (!rstN)
        strb.bmcOdrWr[c] |=> stsByte[c*8 + STS_OBF]);
    end
  endgenerate

  // R2: reads outside the array return zero
  assert_oor_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    bmcValid && !bmcWrite && !inRange |=> bmcRdata == '0);
endmodule

// File: rtl/kcs_mbox_ctrl.sv
module kcs_mbox_ctrl
  import kcs_mbox_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bmcValid,
  input  logic               bmcWrite,
  input  logic [WORD_AW-1:0] bmcAddr,
  input  logic [NUM_CH-1:0]  hostWrEn,
  input  logic [NUM_CH-1:0]  hostWrSel,
  input  logic [NUM_CH-1:0]  hostRdEn,
  input  logic [NUM_CH-1:0]  enRaw,
  input  logic               enGate,
  input  logic [NUM_CH-1:0]  ieRaw,
  input  logic [NUM_CH-1:0]  ibfVec,
  input  logic [NUM_SRC-1:0] irqSrc,
  output flagStrobe_t        strb,
  output logic [NUM_CH-1:0]  kcsIrq,
  output logic               irqAny
);
  logic [NUM_CH-1:0]  chanOn;
  logic [NUM_CH-1:0]  raiseOk;
  logic [NUM_SRC-1:0] pending;
  logic               bmcRd;
  logic               bmcWr;

  assign bmcRd = bmcValid && !bmcWrite;
  assign bmcWr = bmcValid && bmcWrite;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : gChan
      if (c == 2) begin : gDual
        assign chanOn[c] = enRaw[c] && enGate;
      end else begin : gSingle
        assign chanOn[c] = enRaw[c];
      end
      assign raiseOk[c] = chanOn[c] && ieRaw[c];

      assign strb.hostIdrWr[c] = hostWrEn[c] && !hostWrSel[c];
      assign strb.hostOdrRd[c] = hostRdEn[c];
      assign strb.bmcIdrRd[c]  = bmcRd && bmcAddr == WORD_AW'(idrWord(c));
      assign strb.bmcOdrWr[c]  = bmcWr && bmcAddr == WORD_AW'(odrWord(c));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          kcsIrq[c] <= 1'b0;
        else if (strb.hostIdrWr[c] && raiseOk[c])
          kcsIrq[c] <= 1'b1;
        else if (strb.bmcIdrRd[c] && ibfVec[c])
          kcsIrq[c] <= 1'b0;
      end

      // R8: an interrupt only rises after a host data write
      assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
        $rose(kcsIrq[c]) |-> $past(hostWrEn[c] && !hostWrSel[c]));
      // R9: without a controller input read the interrupt holds
      assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
        kcsIrq[c] && !strb.bmcIdrRd[c] |=> kcsIrq[c]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else       pending <= irqSrc;
  end
  assign irqAny = |pending;

  // R10: pending vector follows its level inputs by one edge
  assert_pending_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> pending == $past(irqSrc));
endmodule

// File: rtl/kcs_mbox.sv
module kcs_mbox
  import kcs_mbox_pkg::*;
#(
  parameter int          REG_WORDS = 72,
  parameter int          NUM_SRC   = 5,
  parameter logic [31:0] CFG_RESET = 32'h0000_5A3C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bmcValid,
  input  logic               bmcWrite,
  input  logic [9:0]         bmcAddr,
  input  logic [31:0]        bmcWdata,
  output logic [31:0]        bmcRdata,
  input  logic [3:0]         hostWrEn,
  input  logic [3:0]         hostWrSel,
  input  logic [31:0]        hostWrData,
  input  logic [3:0]         hostRdEn,
  output logic [31:0]        hostRdData,
  output logic [31:0]        hostStatus,
  input  logic [NUM_SRC-1:0] irqSrc,
  output logic [3:0]         kcsIrq,
  output logic               irqAny
);
  flagStrobe_t       strb;
  logic [NUM_CH-1:0] enRaw;
  logic              enGate;
  logic [NUM_CH-1:0] ieRaw;
  logic [NUM_CH-1:0] ibfVec;

  kcs_mbox_ctrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .clk(clk), .rstN(rstN), .bmcValid(bmcValid), .bmcWrite(bmcWrite),
    .bmcAddr(bmcAddr), .hostWrEn(hostWrEn), .hostWrSel(hostWrSel),
    .hostRdEn(hostRdEn), .enRaw(enRaw), .enGate(enGate), .ieRaw(ieRaw),
    .ibfVec(ibfVec), .irqSrc(irqSrc), .strb(strb), .kcsIrq(kcsIrq),
    .irqAny(irqAny)
  );

  kcs_mbox_regs #(.REG_WORDS(REG_WORDS), .DATA_W(8), .CFG_RESET(CFG_RESET)) uRegs (
    .clk(clk), .rstN(rstN), .bmcValid(bmcValid), .bmcWrite(bmcWrite),
    .bmcAddr(bmcAddr), .bmcWdata(bmcWdata), .bmcRdata(bmcRdata),
    .hostWrData(hostWrData), .strb(strb), .enRaw(enRaw), .enGate(enGate),
    .ieRaw(ieRaw), .ibfVec(ibfVec), .odrByte(hostRdData), .stsByte(hostStatus)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : gHostSts
      // R6: a host status write with nothing else on the channel changes no status bit
      assert_host_sts_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
        hostWrEn[c] && hostWrSel[c] && !bmcValid && !hostRdEn[c]
        |=> $stable(hostStatus[c*8 +: 8]));
    end
  endgenerate
endmodule

// File: tb/sim_kcs_mbox.sv
module sim_kcs_mbox;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 72;
  localparam int NS = 5;
  localparam logic [31:0] CFGV = 32'h0000_5A3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bmcValid = 0, bmcWrite = 0;
  logic [9:0]  bmcAddr = '0;
  logic [31:0] bmcWdata = '0;
  logic [31:0] bmcRdata;
  logic [3:0]  hostWrEn = '0, hostWrSel = '0, hostRdEn = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData, hostStatus;
  logic [NS-1:0] irqSrc = '0;
  logic [3:0]  kcsIrq;
  logic        irqAny;

  int nChecks = 0;
  int nFails  = 0;

  kcs_mbox #(.REG_WORDS(NW), .NUM_SRC(NS), .CFG_RESET(CFGV)) u0 (
    .clk(clk), .rstN(rstN), .bmcValid(bmcValid), .bmcWrite(bmcWrite),
    .bmcAddr(bmcAddr), .bmcWdata(bmcWdata), .bmcRdata(bmcRdata),
    .hostWrEn(hostWrEn), .hostWrSel(hostWrSel), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData), .hostStatus(hostStatus),
    .irqSrc(irqSrc), .kcsIrq(kcsIrq), .irqAny(irqAny)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [31:0] m [NW];
  logic [31:0] n [NW];
  logic [31:0] mRd;
  logic [3:0]  mIrq;
  logic [NS-1:0] mPend;

  function automatic int aIdr(input int c); return (c < 3) ? 9 + c  : 69; endfunction
  function automatic int aOdr(input int c); return (c < 3) ? 12 + c : 70; endfunction
  function automatic int aSts(input int c); return (c < 3) ? 15 + c : 71; endfunction

  function automatic logic chOn(input int c);
    case (c)
      0: return m[0][5];
      1: return m[0][6];
      2: return m[0][7] && m[4][2];
      default: return m[64][0];
    endcase
  endfunction
  function automatic logic chIe(input int c);
    case (c)
      0: return m[2][1];
      1: return m[2][2];
      2: return m[2][3];
      default: return m[64][1];
    endcase
  endfunction

  task automatic modelReset();
    for (int w = 0; w < NW; w++) m[w] = (w == 34) ? CFGV : 32'h0;
    mRd = '0; mIrq = '0; mPend = '0;
  endtask

  task automatic modelStep();
    int a;
    a = int'(bmcAddr);
    n = m;
    if (bmcValid && !bmcWrite) mRd = (a < NW) ? m[a] : 32'h0;
    if (bmcValid && bmcWrite && a < NW) n[a] = bmcWdata;
    for (int c = 0; c < 4; c++) begin
      logic hw, bir, bow;
      hw  = hostWrEn[c] && !hostWrSel[c];
      bir = bmcValid && !bmcWrite && a == aIdr(c);
      bow = bmcValid && bmcWrite && a == aOdr(c);
      if (hw) n[aIdr(c)] = {24'h0, hostWrData[c*8 +: 8]};
      if (bir) n[aSts(c)][1] = 1'b0;
      if (hw) n[aSts(c)][1] = 1'b1;
      if (hostRdEn[c]) n[aSts(c)][0] = 1'b0;
      if (bow) n[aSts(c)][0] = 1'b1;
      if (hw && chOn(c) && chIe(c)) mIrq[c] = 1'b1;
      else if (bir && m[aSts(c)][1]) mIrq[c] = 1'b0;
    end
    m = n;
    mPend = irqSrc;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compareAll();
    logic [31:0] es, eo;
    for (int c = 0; c < 4; c++) begin
      es[c*8 +: 8] = m[aSts(c)][7:0];
      eo[c*8 +: 8] = m[aOdr(c)][7:0];
    end
    chk("R2 bmcRdata", bmcRdata, mRd);
    chk("R8 R9 kcsIrq", {28'h0, kcsIrq}, {28'h0, mIrq});
    chk("R10 irqAny", {31'h0, irqAny}, {31'h0, |mPend});
    chk("R3 R4 R6 hostStatus", hostStatus, es);
    chk("R5 hostRdData", hostRdData, eo);
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic clearIn();
    bmcValid = 0; bmcWrite = 0; bmcAddr = '0; bmcWdata = '0;
    hostWrEn = '0; hostWrSel = '0; hostWrData = '0; hostRdEn = '0;
  endtask

  task automatic bmcRd(input int a);
    bmcValid = 1; bmcWrite = 0; bmcAddr = 10'(a);
    tick(); clearIn();
  endtask
  task automatic bmcWr(input int a, input logic [31:0] d);
    bmcValid = 1; bmcWrite = 1; bmcAddr = 10'(a); bmcWdata = d;
    tick(); clearIn();
  endtask
  task automatic hostWr(input int c, input logic [7:0] d, input logic sel);
    hostWrEn[c] = 1'b1; hostWrSel[c] = sel; hostWrData[c*8 +: 8] = d;
    tick(); clearIn();
  endtask
  task automatic hostRd(input int c);
    hostRdEn[c] = 1'b1;
    tick(); clearIn();
  endtask

  function automatic int pickAddr();
    int k, c;
    k = int'($urandom % 10);
    c = int'($urandom % 4);
    case (k)
      0, 1: return aIdr(c);
      2, 3: return aOdr(c);
      4:    return aSts(c);
      5:    return (c == 0) ? 0 : (c == 1) ? 2 : (c == 2) ? 4 : 64;
      6:    return 34;
      default: return int'($urandom % 1024);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareAll();                                  // R1 outputs after reset
    chk("R1 kcsIrq reset", {28'h0, kcsIrq}, 32'h0);
    bmcRd(34);  chk("R1 cfg word reset value", bmcRdata, CFGV);
    bmcRd(0);   chk("R1 word 0 reset zero", bmcRdata, 32'h0);

    // R2 out-of-range
    bmcWr(1000, 32'hDEAD_BEEF);
    bmcRd(1000); chk("R2 out-of-range read zero", bmcRdata, 32'h0);
    bmcRd(72);   chk("R2 first word past array", bmcRdata, 32'h0);

    // R3 / R4
    hostWr(0, 8'hA5, 1'b0);
    chk("R3 ibf set after host write", {31'h0, hostStatus[1]}, 32'h1);
    bmcRd(9);
    chk("R3 idr holds zero-extended byte", bmcRdata, 32'h0000_00A5);
    chk("R4 ibf cleared by controller read", {31'h0, hostStatus[1]}, 32'h0);
    bmcValid = 1; bmcAddr = 10'd9; hostWrEn[0] = 1; hostWrData[7:0] = 8'h11;
    tick(); clearIn();
    chk("R4 same-cycle host write keeps ibf", {31'h0, hostStatus[1]}, 32'h1);
    bmcRd(9);

    // R8 / R9 on channel 0
    bmcWr(0, 32'h20);
    bmcWr(2, 32'h02);
    hostWr(0, 8'h42, 1'b0);
    chk("R8 irq raised when enabled", {31'h0, kcsIrq[0]}, 32'h1);
    bmcRd(9);
    chk("R9 irq dropped by idr read", {31'h0, kcsIrq[0]}, 32'h0);
    hostWr(0, 8'h43, 1'b0);
    bmcWr(15, 32'h0);
    bmcRd(9);
    chk("R9 irq holds when ibf already clear", {31'h0, kcsIrq[0]}, 32'h1);
    bmcWr(15, 32'h2);
    bmcRd(9);
    chk("R9 irq dropped once ibf set", {31'h0, kcsIrq[0]}, 32'h0);

    // R7 channel 2 dual enable
    bmcWr(0, 32'h80);
    bmcWr(2, 32'h08);
    hostWr(2, 8'h01, 1'b0);
    chk("R7 channel 2 silent without second enable", {31'h0, kcsIrq[2]}, 32'h0);
    bmcWr(4, 32'h04);
    hostWr(2, 8'h02, 1'b0);
    chk("R7 channel 2 raised with both enables", {31'h0, kcsIrq[2]}, 32'h1);
    bmcRd(11);

    // R8 channel 3 enable gating
    bmcWr(64, 32'h2);
    hostWr(3, 8'h05, 1'b0);
    chk("R8 ie without channel enable raises nothing", {31'h0, kcsIrq[3]}, 32'h0);
    bmcWr(64, 32'h3);
    hostWr(3, 8'h06, 1'b0);
    chk("R8 channel 3 raised", {31'h0, kcsIrq[3]}, 32'h1);
    bmcRd(69);

    // R5 output path
    bmcWr(13, 32'h0000_003C);
    chk("R5 obf set by controller write", {31'h0, hostStatus[8]}, 32'h1);
    chk("R5 host sees output byte", {24'h0, hostRdData[15:8]}, 32'h3C);
    hostRd(1);
    chk("R5 obf cleared by host read", {31'h0, hostStatus[8]}, 32'h0);
    bmcValid = 1; bmcWrite = 1; bmcAddr = 10'd13; bmcWdata = 32'h77; hostRdEn[1] = 1;
    tick(); clearIn();
    chk("R5 same-cycle write beats host read", {31'h0, hostStatus[8]}, 32'h1);

    // R6 host status write ignored
    hostWr(1, 8'h99, 1'b0);
    hostWr(1, 8'hFF, 1'b1);
    chk("R6 status unchanged by host status write", {24'h0, hostStatus[15:8]}, 32'h03);
    bmcRd(10);
    chk("R6 idr unchanged by host status write", bmcRdata, 32'h99);
    bmcWr(16, 32'h0000_0008);
    chk("R6 controller writes status directly", {24'h0, hostStatus[15:8]}, 32'h08);

    // R10 pending vector
    irqSrc = 5'b00100; tick();
    chk("R10 irqAny high", {31'h0, irqAny}, 32'h1);
    irqSrc = 5'b00000; tick();
    chk("R10 irqAny low", {31'h0, irqAny}, 32'h0);

    // mixed random traffic checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      bmcValid = ($urandom % 3) != 0;
      bmcWrite = $urandom % 2;
      bmcAddr  = 10'(pickAddr());
      bmcWdata = ($urandom % 2) ? $urandom : (32'h1 << ($urandom % 8));
      for (int c = 0; c < 4; c++) begin
        hostWrEn[c]  = ($urandom % 4) == 0;
        hostWrSel[c] = ($urandom % 4) == 0;
        hostRdEn[c]  = ($urandom % 4) == 0;
      end
      hostWrData = $urandom;
      if (($urandom % 8) == 0) irqSrc = NS'($urandom);
      tick();
    end
    clearIn(); irqSrc = '0;
    tick();

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule